// File: doc/BRIEF.md
# Direct-Mapped Branch Target Predictor

This block sits beside the fetch-stage program counter and decides, in the cycle a fetch address is presented, whether the next fetch should leave the sequential path and where it should go. The redirect address comes out combinationally, so a branch predicted correctly costs no bubble. The table has 2^N slots and the slot is picked straight from the fetch address. Each slot holds a valid flag, the full address of a branch, the place that branch last jumped to, and a two-bit saturating confidence counter.

The execute stage reports each resolved branch on an update port: its address, whether it was taken and its destination. The table learns from these reports. A build parameter picks one of three variants. The full-target variant uses the whole table. The history-only variant keeps only the counters and works out the destination from the offset field of the fetched instruction word. The static variant keeps no state and follows a fixed backward-taken rule. A synchronous clear input empties the table at any time.

Top module: `bp_predictor`

## Requirements
- R1: After reset, or after a cycle with `clearAll` high, the full-target variant predicts nothing until new updates arrive, and every counter of the history-only variant reads 1 (weakly not taken).
- R2: The table has 2^IDX_W slots, and both the lookup and the update pick their slot from address bits [IDX_W+1:2]. With the default IDX_W of 4 this covers slot 0 through slot 15.
- R3: In the full-target variant a lookup hits only when the slot is valid and its stored address equals all 32 bits of `fetchPc`. On a hit, `predTaken` equals the counter's upper bit and `predTarget` is the stored destination, both in the same cycle as `fetchPc`.
- R4: Whenever `predTaken` is low, `predTarget` equals `fetchPc + 4`.
- R5: An update that hits its slot moves the counter up by one on a taken outcome and down by one on a not-taken outcome, holding at 3 and at 0.
- R6: An update that misses writes a new slot only when the outcome is taken. The new slot gets address `updPc`, destination `updTarget` and counter 2, and it replaces whatever was in that slot. A not-taken miss leaves the table as it was.
- R7: A taken update that hits replaces the stored destination with `updTarget`.
- R8: When a lookup and an update touch the same slot in one cycle, the lookup sees the contents from before the update, and the write shows up from the next cycle on.
- R9: A cycle with `clearAll` high invalidates every slot, and an update presented in that cycle is dropped.
- R10: The static variant predicts taken for a direct jump (opcode bits [6:0] = 1101111) and for a conditional branch (opcode bits [6:0] = 1100011) whose offset is negative. The offset is sign-extended from {inst[31], inst[7], inst[30:25], inst[11:8], 0} for branches and from {inst[31], inst[19:12], inst[20], inst[30:21], 0} for jumps, and the target is `fetchPc` plus that offset.
- R11: The history-only variant keeps one counter per slot with no address tag. Every update adjusts that counter as in R5. It predicts taken for any direct jump, and for a conditional branch when the counter of the fetch slot has its upper bit set. The target is decoded as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clearAll | input | 1 | Synchronous invalidate of the whole table |
| fetchPc | input | 32 | Address being fetched this cycle |
| fetchInst | input | 32 | Instruction word at `fetchPc` (decoded by the history-only and static variants) |
| predTaken | output | 1 | Redirect the next fetch |
| predTarget | output | 32 | Next fetch address: predicted destination, or `fetchPc + 4` |
| updValid | input | 1 | A resolved branch is reported this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTarget | input | 32 | Resolved destination |
| updTaken | input | 1 | Resolved outcome |

## Verification
The hardest case to reach from the ports is a lookup and an update landing on the same slot in the same cycle, because the update also has to evict or change something the lookup would otherwise see. The stimulus trains one address, then fetches it while reporting a taken branch at an address 2^IDX_W words away. That address aliases to the same slot, so the first cycle must still show the old hit and the next cycle must show the replacement. Counter saturation at both ends, a clear that collides with an update, and the two edge slots are driven directly. A long random stream over a small address pool, with one address set wider than the table, then forces repeated aliasing across all three variants.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam int PC_W   = 32;
  localparam int INST_W = 32;
  localparam int CNT_W  = 2;

  localparam logic [6:0]       OPC_COND = 7'b1100011;
  localparam logic [6:0]       OPC_JUMP = 7'b1101111;
  localparam logic [CNT_W-1:0] CNT_INIT = 2'd1;
  localparam logic [CNT_W-1:0] CNT_NEW  = 2'd2;

  typedef enum logic [1:0] {
    PRED_TARGET  = 2'd0,
    PRED_HISTORY = 2'd1,
    PRED_STATIC  = 2'd2
  } predMode_e;

  // strobes from the control to the table datapath
  typedef struct packed {
    logic             clrAll;
    logic             cntWe;
    logic             entryWe;
    logic [CNT_W-1:0] cntVal;
  } tblStrobe_t;

  function automatic logic isCondBr(input logic [INST_W-1:0] inst);
    return inst[6:0] == OPC_COND;
  endfunction

  function automatic logic isJump(input logic [INST_W-1:0] inst);
    return inst[6:0] == OPC_JUMP;
  endfunction

  function automatic logic [PC_W-1:0] condOffset(input logic [INST_W-1:0] inst);
    return {{19{inst[31]}}, inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};
  endfunction

  function automatic logic [PC_W-1:0] jumpOffset(input logic [INST_W-1:0] inst);
    return {{11{inst[31]}}, inst[31], inst[19:12], inst[20], inst[30:21], 1'b0};
  endfunction

  function automatic logic [CNT_W-1:0] satStep(input logic [CNT_W-1:0] cnt,
                                               input logic taken);
    logic [CNT_W-1:0] nxt;
    if (taken) nxt = (cnt == '1) ? cnt : cnt + 1'b1;
    else       nxt = (cnt == '0) ? cnt : cnt - 1'b1;
    return nxt;
  endfunction

endpackage

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter bit KEEP_ENTRY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tblStrobe_t       strb,
  input  logic [IDX_W-1:0] fetchIdx,
  input  logic [IDX_W-1:0] updIdx,
  input  logic [PC_W-1:0]  wrTag,
  input  logic [PC_W-1:0]  wrTgt,
  output logic             fValid,
  output logic [PC_W-1:0]  fTag,
  output logic [PC_W-1:0]  fTgt,
  output logic [CNT_W-1:0] fCnt,
  output logic             uValid,
  output logic [PC_W-1:0]  uTag,
  output logic [CNT_W-1:0] uCnt
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] validQ;
  logic [CNT_W-1:0]   cntQ [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) cntQ[i] <= CNT_INIT;
    end else if (strb.clrAll) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) cntQ[i] <= CNT_INIT;
    end else begin
      if (strb.entryWe) validQ[updIdx] <= 1'b1;
      if (strb.cntWe)   cntQ[updIdx]   <= strb.cntVal;
    end
  end

  assign fValid = validQ[fetchIdx];
  assign fCnt   = cntQ[fetchIdx];
  assign uValid = validQ[updIdx];
  assign uCnt   = cntQ[updIdx];

  generate
    if (KEEP_ENTRY) begin : gEntry
      logic [PC_W-1:0] tagQ [ENTRIES];
      logic [PC_W-1:0] tgtQ [ENTRIES];

      always_ff @(posedge clk) begin
        if (strb.entryWe && !strb.clrAll) begin
          tagQ[updIdx] <= wrTag;
          tgtQ[updIdx] <= wrTgt;
        end
      end

      assign fTag = tagQ[fetchIdx];
      assign fTgt = tgtQ[fetchIdx];
      assign uTag = tagQ[updIdx];
    end else begin : gNoEntry
      logic unusedWr;
      assign unusedWr = ^{wrTag, wrTgt};
      assign fTag = '0;
      assign fTgt = '0;
      assign uTag = '0;
    end
  endgenerate

endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter predMode_e MODE = PRED_TARGET
) (
  input  logic              clearAll,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [INST_W-1:0] fetchInst,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic              updTaken,
  input  logic              fValid,
  input  logic [PC_W-1:0]   fTag,
  input  logic [PC_W-1:0]   fTgt,
  input  logic [CNT_W-1:0]  fCnt,
  input  logic              uValid,
  input  logic [PC_W-1:0]   uTag,
  input  logic [CNT_W-1:0]  uCnt,
  output logic              predTaken,
  output logic [PC_W-1:0]   predTarget,
  output tblStrobe_t        strb
);

  logic            condBr, jumpOp, fHit, uHit, takenSel;
  logic [PC_W-1:0] seqPc, decTgt, condOff, tgtSel;

  assign condBr  = isCondBr(fetchInst);
  assign jumpOp  = isJump(fetchInst);
  assign condOff = condOffset(fetchInst);
  assign seqPc   = fetchPc + PC_W'(4);
  assign decTgt  = fetchPc + (jumpOp ? jumpOffset(fetchInst) : condOff);
  assign fHit    = fValid && (fTag == fetchPc);
  assign uHit    = uValid && (uTag == updPc);

  // lookup side
  always_comb begin
    case (MODE)
      PRED_TARGET: begin
        takenSel = fHit && fCnt[CNT_W-1];
        tgtSel   = fTgt;
      end
      PRED_HISTORY: begin
        takenSel = jumpOp || (condBr && fCnt[CNT_W-1]);
        tgtSel   = decTgt;
      end
      default: begin
        takenSel = jumpOp || (condBr && condOff[PC_W-1]);
        tgtSel   = decTgt;
      end
    endcase
  end

  assign predTaken  = takenSel;
  assign predTarget = takenSel ? tgtSel : seqPc;

  // update side
  always_comb begin
    strb        = '0;
    strb.clrAll = clearAll;
    if (!clearAll && updValid) begin
      case (MODE)
        PRED_TARGET: begin
          if (uHit) begin
            strb.cntWe   = 1'b1;
            strb.cntVal  = satStep(uCnt, updTaken);
            strb.entryWe = updTaken;
          end else if (updTaken) begin
            strb.cntWe   = 1'b1;
            strb.cntVal  = CNT_NEW;
            strb.entryWe = 1'b1;
          end
        end
        PRED_HISTORY: begin
          strb.cntWe  = 1'b1;
          strb.cntVal = satStep(uCnt, updTaken);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
  import bp_pkg::*;
#(
  parameter int        IDX_W = 4,
  parameter predMode_e MODE  = PRED_TARGET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clearAll,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [INST_W-1:0] fetchInst,
  output logic              predTaken,
  output logic [PC_W-1:0]   predTarget,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic [PC_W-1:0]   updTarget,
  input  logic              updTaken
);

  localparam bit KEEP_ENTRY = (MODE == PRED_TARGET);

  tblStrobe_t       strb;
  logic             fValid, uValid;
  logic [PC_W-1:0]  fTag, fTgt, uTag;
  logic [CNT_W-1:0] fCnt, uCnt;

  bp_table #(
    .IDX_W     (IDX_W),
    .KEEP_ENTRY(KEEP_ENTRY)
  ) uTable (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .fetchIdx(fetchPc[IDX_W+1:2]),
    .updIdx  (updPc[IDX_W+1:2]),
    .wrTag   (updPc),
    .wrTgt   (updTarget),
    .fValid  (fValid),
    .fTag    (fTag),
    .fTgt    (fTgt),
    .fCnt    (fCnt),
    .uValid  (uValid),
    .uTag    (uTag),
    .uCnt    (uCnt)
  );

  bp_ctrl #(
    .MODE(MODE)
  ) uCtrl (
    .clearAll  (clearAll),
    .fetchPc   (fetchPc),
    .fetchInst (fetchInst),
    .updValid  (updValid),
    .updPc     (updPc),
    .updTaken  (updTaken),
    .fValid    (fValid),
    .fTag      (fTag),
    .fTgt      (fTgt),
    .fCnt      (fCnt),
    .uValid    (uValid),
    .uTag      (uTag),
    .uCnt      (uCnt),
    .predTaken (predTaken),
    .predTarget(predTarget),
    .strb      (strb)
  );

endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk
  import bp_pkg::*;
#(
  parameter int        IDX_W = 4,
  parameter predMode_e MODE  = PRED_TARGET
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clearAll,
  input logic [PC_W-1:0]   fetchPc,
  input logic [INST_W-1:0] fetchInst,
  input logic              predTaken,
  input logic [PC_W-1:0]   predTarget,
  input logic              updValid,
  input logic              updTaken
);

  logic sawTaken;
  logic unusedIdx;
  assign unusedIdx = (IDX_W > 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              sawTaken <= 1'b0;
    else if (clearAll)                       sawTaken <= 1'b0;
    else if (updValid && updTaken)           sawTaken <= 1'b1;
  end

  assert_seq_fallthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !predTaken |-> predTarget == fetchPc + PC_W'(4));

  assert_known_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(predTaken));

  generate
    if (MODE == PRED_TARGET) begin : gTgtChk
      assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clearAll |=> !predTaken);

      assert_needs_taken_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        predTaken |-> sawTaken);
    end else begin : gDecChk
      assert_decoded_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        predTaken |-> (fetchInst[6:0] == OPC_COND || fetchInst[6:0] == OPC_JUMP));
    end
  endgenerate

endmodule

bind bp_predictor bp_predictor_chk #(.IDX_W(IDX_W), .MODE(MODE)) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clearAll  (clearAll),
  .fetchPc   (fetchPc),
  .fetchInst (fetchInst),
  .predTaken (predTaken),
  .predTarget(predTarget),
  .updValid  (updValid),
  .updTaken  (updTaken)
);

// File: tb/sim_bp_predictor.sv
`timescale 1ns/1ps
module sim_bp_predictor;
  import bp_pkg::*;

  localparam int IDX  = 4;
  localparam int NENT = 1 << IDX;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clearAll = 1'b0;
  logic [31:0] fetchPc = '0;
  logic [31:0] fetchInst = 32'h00a00093;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [31:0] updTarget = '0;
  logic        updTaken = 1'b0;

  logic        tk0, tk1, tk2;
  logic [31:0] tg0, tg1, tg2;

  always #4 clk = ~clk;

  bp_predictor #(.IDX_W(IDX), .MODE(PRED_TARGET)) u0 (
    .clk(clk), .rst_n(rst_n), .clearAll(clearAll), .fetchPc(fetchPc),
    .fetchInst(fetchInst), .predTaken(tk0), .predTarget(tg0),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget), .updTaken(updTaken));

  bp_predictor #(.IDX_W(IDX), .MODE(PRED_STATIC)) u1 (
    .clk(clk), .rst_n(rst_n), .clearAll(clearAll), .fetchPc(fetchPc),
    .fetchInst(fetchInst), .predTaken(tk1), .predTarget(tg1),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget), .updTaken(updTaken));

  bp_predictor #(.IDX_W(IDX), .MODE(PRED_HISTORY)) u2 (
    .clk(clk), .rst_n(rst_n), .clearAll(clearAll), .fetchPc(fetchPc),
    .fetchInst(fetchInst), .predTaken(tk2), .predTarget(tg2),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget), .updTaken(updTaken));

  // reference state
  bit          mValid [NENT];
  logic [31:0] mTag   [NENT];
  logic [31:0] mTgt   [NENT];
  int          mCnt   [NENT];
  int          mHist  [NENT];

  int    checks = 0;
  int    fails  = 0;
  string curReq = "R1";
  int    curKind = 0;
  int    curOff  = 0;

  function automatic logic [31:0] encCond(input int off);
    logic [12:0] i;
    i = off[12:0];
    return {i[12], i[10:5], 5'd2, 5'd1, 3'b000, i[4:1], i[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] encJump(input int off);
    logic [20:0] i;
    i = off[20:0];
    return {i[20], i[10:1], i[11], i[19:12], 5'd1, 7'b1101111};
  endfunction

  function automatic int idxOf(input logic [31:0] pc);
    return int'(pc[IDX+1:2]);
  endfunction

  task automatic modelClear();
    for (int i = 0; i < NENT; i++) begin
      mValid[i] = 1'b0;
      mCnt[i]   = 1;
      mHist[i]  = 1;
    end
  endtask

  task automatic check1(input string who, input string req, input logic aTk,
                        input logic [31:0] aTg, input logic eTk, input logic [31:0] eTg);
    checks++;
    if (aTk !== eTk || aTg !== eTg) begin
      fails++;
      $display("FAIL %s %s pc=%h: taken=%0b target=%h expected taken=%0b target=%h",
               req, who, fetchPc, aTk, aTg, eTk, eTg);
    end
  endtask

  task automatic compareAll();
    int          ix;
    logic        eTk;
    logic [31:0] eTg, dec, seq;
    ix  = idxOf(fetchPc);
    seq = fetchPc + 32'd4;
    dec = fetchPc + 32'(curOff);
    // full-target variant
    eTk = mValid[ix] && (mTag[ix] == fetchPc) && (mCnt[ix] >= 2);
    eTg = eTk ? mTgt[ix] : seq;
    check1("u0", curReq, tk0, tg0, eTk, eTg);
    // static variant
    eTk = (curKind == 2) || (curKind == 1 && curOff < 0);
    eTg = eTk ? dec : seq;
    check1("u1", "R10", tk1, tg1, eTk, eTg);
    // history-only variant
    eTk = (curKind == 2) || (curKind == 1 && mHist[ix] >= 2);
    eTg = eTk ? dec : seq;
    check1("u2", "R11", tk2, tg2, eTk, eTg);
  endtask

  task automatic modelUpdate();
    int ix;
    if (clearAll) begin
      modelClear();
    end else if (updValid) begin
      ix = idxOf(updPc);
      if (mValid[ix] && mTag[ix] == updPc) begin
        mCnt[ix] = updTaken ? ((mCnt[ix] < 3) ? mCnt[ix] + 1 : 3)
                            : ((mCnt[ix] > 0) ? mCnt[ix] - 1 : 0);
        if (updTaken) mTgt[ix] = updTarget;
      end else if (updTaken) begin
        mValid[ix] = 1'b1;
        mTag[ix]   = updPc;
        mTgt[ix]   = updTarget;
        mCnt[ix]   = 2;
      end
      mHist[ix] = updTaken ? ((mHist[ix] < 3) ? mHist[ix] + 1 : 3)
                           : ((mHist[ix] > 0) ? mHist[ix] - 1 : 0);
    end
  endtask

  // one cycle: inputs already set just after a rising edge
  task automatic cyc();
    @(negedge clk);
    compareAll();
    @(posedge clk);
    modelUpdate();
    #1;
  endtask

  task automatic drive(input logic [31:0] pc, input int kind, input int off,
                       input logic uv, input logic [31:0] upc, input logic [31:0] utg,
                       input logic utk, input logic clr);
    fetchPc   = pc;
    curKind   = kind;
    curOff    = off;
    fetchInst = (kind == 1) ? encCond(off) : (kind == 2) ? encJump(off) : 32'h00a00093;
    updValid  = uv;
    updPc     = upc;
    updTarget = utg;
    updTaken  = utk;
    clearAll  = clr;
    cyc();
  endtask

  task automatic fetchOnly(input logic [31:0] pc, input int kind, input int off);
    drive(pc, kind, off, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic upd(input logic [31:0] fpc, input logic [31:0] upc,
                     input logic [31:0] utg, input logic utk);
    drive(fpc, 0, 0, 1'b1, upc, utg, utk, 1'b0);
  endtask

  localparam logic [31:0] PA = 32'h0000_1008;  // slot 2
  localparam logic [31:0] PB = 32'h0000_1010;  // slot 4
  localparam logic [31:0] PC = 32'h0000_1014;  // slot 5
  localparam logic [31:0] TA = 32'h0000_2000;
  localparam logic [31:0] TB = 32'h0000_3000;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    modelClear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: nothing predicted after reset, history counters weakly not taken
    curReq = "R1";
    fetchOnly(PA, 1, -16);
    fetchOnly(PB, 1, 32);
    fetchOnly(PC, 2, 256);

    // R6: taken miss allocates, not-taken miss does not
    curReq = "R6";
    upd(PC, PA, TA, 1'b1);
    curReq = "R3";
    fetchOnly(PA, 1, -8);
    curReq = "R6";
    upd(PA, PB, TB, 1'b0);
    fetchOnly(PB, 1, -8);

    // R5: counter walks down to 0 and up to 3, saturating
    curReq = "R5";
    for (int i = 0; i < 3; i++) begin
      upd(PC, PA, TA, 1'b0);
      fetchOnly(PA, 1, -4);
    end
    for (int i = 0; i < 5; i++) begin
      upd(PC, PA, TA, 1'b1);
      fetchOnly(PA, 1, 12);
    end
    upd(PC, PA, TA, 1'b0);
    fetchOnly(PA, 0, 0);

    // R7: taken hit refreshes destination
    curReq = "R7";
    upd(PC, PA, TB, 1'b1);
    fetchOnly(PA, 2, -64);

    // R3: same slot, other address: no hit
    curReq = "R3";
    fetchOnly(PA + 32'(NENT * 4), 0, 0);

    // R8: lookup of PA while an aliasing taken update replaces its slot
    curReq = "R8";
    drive(PA, 1, -20, 1'b1, PA + 32'(NENT * 4), TA + 32'h40, 1'b1, 1'b0);
    curReq = "R6";
    fetchOnly(PA, 1, -20);
    fetchOnly(PA + 32'(NENT * 4), 0, 0);

    // R9: clear colliding with a taken update: update dropped
    curReq = "R9";
    upd(PC, PB, TB, 1'b1);
    drive(PB, 1, -8, 1'b1, PA, TA, 1'b1, 1'b1);
    fetchOnly(PA, 1, -8);
    fetchOnly(PB, 1, -8);
    fetchOnly(PA + 32'(NENT * 4), 0, 0);

    // R2: edge slots 0 and NENT-1
    curReq = "R2";
    upd(PC, 32'h0000_1040, 32'h0000_4000, 1'b1);
    upd(32'h0000_1040, 32'h0000_103C, 32'h0000_5000, 1'b1);
    fetchOnly(32'h0000_103C, 1, 100);
    fetchOnly(32'h0000_1040, 2, -2048);
    fetchOnly(32'h0000_1000, 0, 0);

    // R4 and all rules: random stream over a pool wider than the table
    curReq = "R4";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] fp, up;
      int          kd, of;
      fp = 32'h0000_1000 + 32'(($urandom % 40) * 4);
      up = 32'h0000_1000 + 32'(($urandom % 40) * 4);
      kd = int'($urandom % 3);
      of = (int'($urandom % 512) - 256) * 4;
      drive(fp, kd, of, ($urandom % 4) != 0, up,
            32'h0000_8000 + 32'(($urandom % 256) * 4), $urandom % 2 == 0,
            ($urandom % 60) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule